// File: doc/BRIEF.md
# One-Wire Search Path Accelerator

This block is the byte engine of a one-wire bus controller with an optional search acceleration mode. In its ordinary mode each byte the host hands over is sent as eight bit slots, least significant bit first. The level sampled in each slot is gathered into a returned byte, so a byte of ones reads a byte from the bus.

With the search mode enabled, each accepted byte instead carries four path choices for four consecutive ROM bit positions. For every position the engine runs three slots: read the bit, read its complement, then write the chosen direction. It returns one byte in which the chosen bits and the discrepancy flags are interleaved. Sixteen such exchanges walk all 64 ROM bits. The host still decides which branch the next pass takes. The bus itself is reached through a slot handshake: the engine asks for one slot with the bit to drive, and the bus side acknowledges with the sampled level.

Top module: `owsa_engine`

## Requirements
- R1: After reset, busy, slot_req, out_done and rx_full are 0 and out_byte is 0.
- R2: With the mode sampled off, a byte takes exactly 8 slots. Slot k drives bit k of the input byte, and bit k of out_byte is the level sampled in slot k.
- R3: With the mode sampled on, a byte takes exactly 12 slots, three per lane, lanes in ascending order. The first two slots of a lane drive 1, so they act as read slots, and the third drives the chosen bit.
- R4: In search mode the path choice of lane l (l = 0..3, lane 0 the lowest ROM bit) is input bit 2l+1. Input bits 0, 2, 4 and 6 have no effect on the slots or on the result.
- R5: If the two reads of a lane differ, the chosen bit is the first read and the discrepancy flag is 0. If both read 0, the flag is 1 and the path bit is written and chosen. If both read 1, the flag is 1 and the chosen bit is 1.
- R6: In search mode, bit 2l+1 of out_byte holds lane l's chosen bit and bit 2l holds its discrepancy flag.
- R7: Sixteen consecutive search bytes resolve ROM bits 0 to 63, byte i covering bits 4i to 4i+3. When no device answers, bit 63 comes back with both the chosen bit and the flag set, which marks a bus error.
- R8: out_done is a one-cycle pulse. It arrives on the clock edge that accepts the last slot's acknowledge, and out_byte keeps its value until the next pulse.
- R9: rx_full sets together with out_done and clears on out_read. If both happen in the same cycle, the set wins.
- R10: An in_valid that arrives while busy is 1 is ignored.
- R11: The mode is sampled when a byte is accepted. Changing search_en mid-byte does not alter that byte.
- R12: slot_req stays high until slot_ack is seen and drops on the next cycle. Only one slot is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_en | input | 1 | Search acceleration mode enable |
| in_valid | input | 1 | Strobe: in_byte holds a new byte |
| in_byte | input | 2*LANES | Byte to send, or path choices in search mode |
| out_read | input | 1 | Host has taken out_byte; clears rx_full |
| out_byte | output | 2*LANES | Received byte, or interleaved search result |
| out_done | output | 1 | One-cycle pulse: byte finished |
| rx_full | output | 1 | Unread result pending |
| busy | output | 1 | A byte is in progress |
| slot_req | output | 1 | Request for one bit slot |
| slot_wbit | output | 1 | Bit to drive in the requested slot |
| slot_ack | input | 1 | Bus side finished the slot |
| slot_rbit | input | 1 | Level sampled in the slot, valid with slot_ack |

## Verification
Two actions can land on the same edge. One is the completion of a byte, which raises rx_full. The other is a host read strobe, which lowers it. The bench holds out_read high for a whole transfer, so the read strobe is present on the finishing edge. It then expects rx_full to be 1 in the cycle of out_done and 0 one cycle later. A second overlap is a fresh in_valid, together with a mode change, that arrives while a byte is still running. It is judged by the slot count, the returned value and the absence of any extra completion pulse.

// File: rtl/owsa_pkg.sv
package owsa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_st_e;
  typedef enum logic [1:0] {PH_ID, PH_CMP, PH_WR} lane_ph_e;
endpackage

// File: rtl/owsa_decide.sv
// Direction choice for one ROM position from the bit/complement pair.
module owsa_decide (
  input  logic id_bit,
  input  logic cmp_bit,
  input  logic path_bit,
  output logic dir_bit,
  output logic disc_bit
);
  always_comb begin
    unique case ({id_bit, cmp_bit})
      2'b10:   begin dir_bit = 1'b1;     disc_bit = 1'b0; end
      2'b01:   begin dir_bit = 1'b0;     disc_bit = 1'b0; end
      2'b00:   begin dir_bit = path_bit; disc_bit = 1'b1; end
      default: begin dir_bit = 1'b1;     disc_bit = 1'b1; end
    endcase
  end
endmodule

// File: rtl/owsa_seq.sv
// Slot sequencer: plain byte mode (one slot per bit) or search mode
// (three slots per lane).
module owsa_seq import owsa_pkg::*; #(
  parameter  int LANES  = 4,
  localparam int BYTE_W = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode,
  input  logic [BYTE_W-1:0] din,
  input  logic [LANES-1:0]  path_in,
  input  logic [BYTE_W-1:0] packed_in,
  output logic [LANES-1:0]  dir_o,
  output logic [LANES-1:0]  disc_o,
  output logic [BYTE_W-1:0] res_o,
  output logic              done_o,
  output logic              fin_o,
  output logic              busy_o,
  output logic              req_o,
  output logic              wbit_o,
  input  logic              ack_i,
  input  logic              rbit_i
);
  localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  seq_st_e           state_q;
  lane_ph_e          ph_q;
  logic              srch_q;
  logic [BYTE_W-1:0] data_q;
  logic [LANES-1:0]  path_q;
  logic [IW-1:0]     bit_q;
  logic [LW-1:0]     lane_q;
  logic              id_q, cmp_q;
  logic [BYTE_W-1:0] shift_q, nxt_shift;
  logic              dir_w, disc_w, last_slot, accept;

  owsa_decide u_decide (
    .id_bit  (id_q),
    .cmp_bit (cmp_q),
    .path_bit(path_q[lane_q]),
    .dir_bit (dir_w),
    .disc_bit(disc_w)
  );

  assign accept    = start && (state_q == ST_IDLE);
  assign last_slot = srch_q ? ((ph_q == PH_WR) && (lane_q == LW'(LANES - 1)))
                            : (bit_q == IW'(BYTE_W - 1));
  assign fin_o     = (state_q == ST_WAIT) && ack_i && last_slot;
  assign busy_o    = (state_q != ST_IDLE);

  always_comb begin
    nxt_shift        = shift_q;
    nxt_shift[bit_q] = rbit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ph_q    <= PH_ID;
      srch_q  <= 1'b0;
      data_q  <= '0;
      path_q  <= '0;
      bit_q   <= '0;
      lane_q  <= '0;
      id_q    <= 1'b0;
      cmp_q   <= 1'b0;
      shift_q <= '0;
      dir_o   <= '0;
      disc_o  <= '0;
      res_o   <= '0;
      done_o  <= 1'b0;
      req_o   <= 1'b0;
      wbit_o  <= 1'b1;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            srch_q  <= mode;
            data_q  <= din;
            path_q  <= path_in;
            bit_q   <= '0;
            lane_q  <= '0;
            ph_q    <= PH_ID;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          req_o <= 1'b1;
          if (!srch_q) begin
            wbit_o <= data_q[bit_q];
          end else if (ph_q == PH_WR) begin
            wbit_o         <= dir_w;
            dir_o[lane_q]  <= dir_w;
            disc_o[lane_q] <= disc_w;
          end else begin
            wbit_o <= 1'b1;
          end
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ack_i) begin
            req_o <= 1'b0;
            if (srch_q) begin
              unique case (ph_q)
                PH_ID:   begin id_q  <= rbit_i; ph_q <= PH_CMP; end
                PH_CMP:  begin cmp_q <= rbit_i; ph_q <= PH_WR;  end
                default: begin
                  ph_q <= PH_ID;
                  if (!last_slot) lane_q <= lane_q + 1'b1;
                end
              endcase
            end else begin
              shift_q <= nxt_shift;
              if (!last_slot) bit_q <= bit_q + 1'b1;
            end
            if (last_slot) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              res_o   <= srch_q ? packed_in : nxt_shift;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R12: a slot request is held until acknowledged, then released
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> req_o);
  a_r12_req_drop: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> !req_o);
  // R8: completion strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10: no slot traffic while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !req_o);
endmodule

// File: rtl/owsa_engine.sv
// One-wire byte engine with a search acceleration mode.
module owsa_engine #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               search_en,
  input  logic               in_valid,
  input  logic [2*LANES-1:0] in_byte,
  input  logic               out_read,
  output logic [2*LANES-1:0] out_byte,
  output logic               out_done,
  output logic               rx_full,
  output logic               busy,
  output logic               slot_req,
  output logic               slot_wbit,
  input  logic               slot_ack,
  input  logic               slot_rbit
);
  localparam int BYTE_W = 2 * LANES;

  logic [LANES-1:0]  path_v, dir_v, disc_v;
  logic [BYTE_W-1:0] packed_v;
  logic              fin_w;

  // Odd input bits carry path choices; result interleaves chosen/flag.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign path_v[l]       = in_byte[2*l+1];
    assign packed_v[2*l+1] = dir_v[l];
    assign packed_v[2*l]   = disc_v[l];
  end

  owsa_seq #(.LANES(LANES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (in_valid),
    .mode     (search_en),
    .din      (in_byte),
    .path_in  (path_v),
    .packed_in(packed_v),
    .dir_o    (dir_v),
    .disc_o   (disc_v),
    .res_o    (out_byte),
    .done_o   (out_done),
    .fin_o    (fin_w),
    .busy_o   (busy),
    .req_o    (slot_req),
    .wbit_o   (slot_wbit),
    .ack_i    (slot_ack),
    .rbit_i   (slot_rbit)
  );

  // Set has priority over the host read strobe.
  always_ff @(posedge clk) begin
    if (rst)         rx_full <= 1'b0;
    else if (fin_w)  rx_full <= 1'b1;
    else if (out_read) rx_full <= 1'b0;
  end

  // R9: pending flag is up whenever completion is signalled
  a_r9_full_with_done: assert property (@(posedge clk) disable iff (rst)
    out_done |-> rx_full);
  // R8: completion only follows an acknowledged slot
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (rst)
    out_done |-> $past(slot_ack));
endmodule

// File: tb/owsa_engine_tb.sv
module owsa_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [63:0] ROM_A = 64'hA5C3_0F1E_7788_9900;
  localparam logic [63:0] ROM_B = 64'hA5C3_0F1E_7788_9920;
  // normal-mode vectors: {in_byte, pull-low mask, expected result}
  localparam logic [23:0] NVEC [0:4] = '{24'hFF_00_FF, 24'hFF_A5_5A,
                                        24'h3C_0F_30, 24'h00_FF_00,
                                        24'h81_01_80};

  logic clk = 0, rst = 1;
  logic search_en = 0, in_valid = 0, out_read = 0;
  logic [7:0] in_byte = 0;
  logic [7:0] out_byte;
  logic out_done, rx_full, busy, slot_req, slot_wbit;
  logic slot_ack = 0, slot_rbit = 1;

  int checks = 0, fails = 0;
  // bus model state
  logic bus_search = 0;
  logic [7:0] pull_mask = 0;
  int slot_cnt = 0;
  logic [11:0] wrec = 0;
  logic en_a = 0, en_b = 0, act_a = 0, act_b = 0;
  int si = 0, sp = 0;
  logic [63:0] rp, dd;
  logic [7:0] raw [16];

  owsa_engine dut_i (
    .clk(clk), .rst(rst), .search_en(search_en), .in_valid(in_valid),
    .in_byte(in_byte), .out_read(out_read), .out_byte(out_byte),
    .out_done(out_done), .rx_full(rx_full), .busy(busy),
    .slot_req(slot_req), .slot_wbit(slot_wbit), .slot_ack(slot_ack),
    .slot_rbit(slot_rbit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bus side: acknowledges each slot with a wired-AND sampled level.
  initial begin
    forever begin
      @(negedge clk);
      if (slot_req && !slot_ack) begin
        logic v;
        @(negedge clk);
        v = slot_wbit;
        if (slot_cnt < 12) wrec[slot_cnt] = slot_wbit;
        if (!bus_search) begin
          if (slot_cnt < 8) v = v & ~pull_mask[slot_cnt];
        end else if (sp == 0) begin
          if (act_a) v = v & ROM_A[si];
          if (act_b) v = v & ROM_B[si];
        end else if (sp == 1) begin
          if (act_a) v = v & ~ROM_A[si];
          if (act_b) v = v & ~ROM_B[si];
        end else begin
          if (act_a && ROM_A[si] != slot_wbit) act_a = 0;
          if (act_b && ROM_B[si] != slot_wbit) act_b = 0;
        end
        if (bus_search) begin
          if (sp == 2) begin sp = 0; si++; end else sp++;
        end
        slot_cnt++;
        slot_rbit = v;
        slot_ack  = 1;
        @(negedge clk);
        slot_ack  = 0;
      end
    end
  end

  task automatic bus_reset();
    act_a = en_a; act_b = en_b; si = 0; sp = 0;
  endtask

  task automatic send_byte(input logic m, input logic [7:0] b,
                           output logic [7:0] res, output int slots,
                           output logic ok);
    bus_search = m; slot_cnt = 0; wrec = 0;
    @(negedge clk);
    search_en = m; in_byte = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    ok = 0;
    for (int t = 0; t < 400; t++) begin
      if (out_done) begin ok = 1; break; end
      @(negedge clk);
    end
    res = out_byte; slots = slot_cnt;
  endtask

  task automatic search_pass(input logic [63:0] r, input logic [7:0] even_fill,
                             output int bad_slots);
    logic [7:0] b, o; int s; logic ok;
    bus_reset(); rp = 0; dd = 0; bad_slots = 0;
    for (int i = 0; i < 16; i++) begin
      b = even_fill & 8'h55;
      for (int l = 0; l < 4; l++) b[2*l+1] = r[4*i+l];
      send_byte(1'b1, b, o, s, ok);
      if (!ok || s != 12 || wrec[0] != 1 || wrec[1] != 1) bad_slots++;
      raw[i] = o;
      for (int l = 0; l < 4; l++) begin
        rp[4*i+l] = o[2*l+1];
        dd[4*i+l] = o[2*l];
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] res; int slots; logic ok; int bad; int extra;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(slot_req == 0, "R1 slot_req", slot_req, 0);
    chk(out_done == 0, "R1 out_done", out_done, 0);
    chk(rx_full == 0, "R1 rx_full", rx_full, 0);
    chk(out_byte == 0, "R1 out_byte", out_byte, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R2 normal-mode vector table
    for (int v = 0; v < 5; v++) begin
      pull_mask = NVEC[v][15:8];
      send_byte(1'b0, NVEC[v][23:16], res, slots, ok);
      chk(ok && res == NVEC[v][7:0], "R2 result", res, NVEC[v][7:0]);
      chk(wrec[7:0] == NVEC[v][23:16], "R2 write order", wrec[7:0], NVEC[v][23:16]);
      chk(slots == 8, "R8 slots before done", slots, 8);
      chk(rx_full == 1, "R9 set with done", rx_full, 1);
      @(negedge clk);
      chk(out_done == 0, "R8 single pulse", out_done, 0);
      chk(out_byte == NVEC[v][7:0], "R8 result held", out_byte, NVEC[v][7:0]);
    end
    pull_mask = 0;
    // R9 clear by read
    out_read = 1; @(negedge clk); out_read = 0;
    chk(rx_full == 0, "R9 clear by read", rx_full, 0);

    // R9 collision: read strobe held across completion edge
    out_read = 1;
    send_byte(1'b0, 8'h5A, res, slots, ok);
    chk(rx_full == 1, "R9 set wins", rx_full, 1);
    @(negedge clk);
    chk(rx_full == 0, "R9 clears after", rx_full, 0);
    out_read = 0;

    // R10/R11: new strobe and mode change during a running byte
    bus_search = 0; slot_cnt = 0; wrec = 0;
    @(negedge clk);
    search_en = 0; in_byte = 8'hC3; in_valid = 1;
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);
    search_en = 1; in_byte = 8'h00; in_valid = 1;
    @(negedge clk); in_valid = 0;
    ok = 0;
    for (int t = 0; t < 400; t++) begin
      if (out_done) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(ok && out_byte == 8'hC3, "R10 R11 result", out_byte, 8'hC3);
    chk(slot_cnt == 8, "R11 slot count", slot_cnt, 8);
    extra = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (out_done || busy) extra++;
    end
    chk(extra == 0, "R10 no second byte", extra, 0);
    search_en = 0;

    // R4 R5 R6 R7: two devices differing at ROM bit 5, path 0, even bits set
    en_a = 1; en_b = 1;
    search_pass(64'h0, 8'hFF, bad);
    chk(bad == 0, "R3 slots per search byte", bad, 0);
    chk(rp == ROM_A, "R4 R5 path 0 chosen ROM", rp, ROM_A);
    chk(dd == 64'h20, "R5 discrepancy at bit 5", dd, 64'h20);
    chk(raw[1] == 8'h04, "R6 interleaved byte 1", raw[1], 8'h04);
    chk(raw[0] == 8'h00, "R7 byte 0 covers bits 0-3", raw[0], 8'h00);
    // second pass takes the 1 branch
    search_pass(64'h20, 8'h00, bad);
    chk(rp == ROM_B, "R5 path 1 chosen ROM", rp, ROM_B);
    chk(dd == 64'h20, "R5 flag on second pass", dd, 64'h20);
    chk(raw[1] == 8'h0C, "R6 chosen and flag in lane 1", raw[1], 8'h0C);
    // single device: no discrepancies
    en_b = 0;
    search_pass(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, bad);
    chk(rp == ROM_A, "R5 single device bits", rp, ROM_A);
    chk(dd == 64'h0, "R5 no flags single device", dd, 0);
    // no device: bus error marking
    en_a = 0;
    search_pass(64'h0, 8'h00, bad);
    chk(rp[63] && dd[63], "R7 bus error at bit 63", {rp[63], dd[63]}, 2'b11);
    chk(rp == '1 && dd == '1, "R5 both-one reads", rp & dd, 64'hFFFF_FFFF_FFFF_FFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule